// File: doc/BRIEF.md
# Banked Shadow Register File

This block is the integer general-register storage of a processor core, replicated into several complete sets of 32 registers. When an interrupt is taken, the interrupt logic asks for a switch to a chosen set, and the handler runs on its own registers at once, with no software save or restore. On return from the handler, the set that was active before the interrupt becomes active again. Register 0 is wired to zero in every set.

Two read ports and one write port serve the pipeline. Port B always reads the current set. Port A and the write port can each be pointed at the previous set (the set that was active when the interrupt was taken). This lets a handler move values into and out of the interrupted context. A write and a read of the same register in the same set during the same cycle return the value being written.

Top module: `bank_regfile`

## Requirements
- R1: After reset, both the current set number and the previous set number are 0.
- R2: Register address 0 reads as 0 on both ports in every set, and a write to address 0 changes nothing.
- R3: A value written to register r (1 to 31) of a set is read back from register r of that set, and is not seen in any other set.
- R4: When wr_en is high and the write targets the same nonzero register in the same set as a read port, that port returns wr_data in the same cycle.
- R5: When irq_enter is high with a valid irq_set, at the next clock edge prev_set takes the old cur_set and cur_set takes irq_set. A write issued in that same cycle goes to the old current set.
- R6: irq_enter with irq_set of NUM_SETS or more changes neither cur_set nor prev_set.
- R7: When irq_return is high and irq_enter is low, at the next edge cur_set takes prev_set and prev_set is unchanged. When both are high, the entry wins.
- R8: With rd_a_prev high, port A reads the previous set. With wr_prev high, the write goes to the previous set, and the current set is left untouched.
- R9: With neither irq_enter nor irq_return high, cur_set and prev_set keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | 5 | Port A register address |
| rd_a_prev | input | 1 | Port A reads the previous set when high |
| rd_a_data | output | 32 | Port A read data |
| rd_b_addr | input | 5 | Port B register address (current set) |
| rd_b_data | output | 32 | Port B read data |
| wr_en | input | 1 | Write enable |
| wr_prev | input | 1 | Write goes to the previous set when high |
| wr_addr | input | 5 | Write register address |
| wr_data | input | 32 | Write data |
| irq_enter | input | 1 | Switch request on interrupt entry |
| irq_set | input | 3 | Target set for the switch |
| irq_return | input | 1 | Return request; restores the previous set |
| cur_set | output | 3 | Current set number |
| prev_set | output | 3 | Previous set number |

## Verification
Every set is filled with a pattern that mixes the set number and the register number. All sets are then read back through both ports. A register that aliases across sets, or an address decode that is off, shows up as a wrong pattern. Writes are checked against a same-cycle read, which tests the bypass. A write to register 0 is also tried, to show that it has no effect.

The switching controls are exercised in several cases: a valid target, an out-of-range target, a return, simultaneous entry and return, and a write in the switch cycle. Together these separate the next-state priorities and show which set a write lands in. Cross-set moves are exercised by writing through the previous-set path and reading on both ports, which shows that only the previous set changed.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int SET_W  = 3;
  localparam int ADDR_W = 5;
  localparam int NREGS  = 32;
  typedef logic [SET_W-1:0] set_idx_t;
endpackage

// File: rtl/rf_set_ctrl.sv
module rf_set_ctrl
  import rf_pkg::*;
#(
  parameter int NUM_SETS = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     irq_enter,
  input  set_idx_t irq_set,
  input  logic     irq_return,
  output set_idx_t cur_q,
  output set_idx_t prev_q
);
  set_idx_t cur_d, prev_d;
  logic     enter_ok;

  assign enter_ok = irq_enter && ({1'b0, irq_set} < (SET_W+1)'(NUM_SETS));

  always_comb begin
    cur_d  = cur_q;
    prev_d = prev_q;
    if (enter_ok) begin
      prev_d = cur_q;
      cur_d  = irq_set;
    end else if (irq_return && !irq_enter) begin
      cur_d  = prev_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [XLEN-1:0]   rdata_a,
  output logic [XLEN-1:0]   rdata_b
);
  logic [XLEN-1:0] mem [1:NREGS-1];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) mem[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : mem[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : mem[raddr_b];
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int XLEN     = 32
) (
  input  logic [XLEN-1:0]   bank_data [NUM_SETS],
  input  set_idx_t          sel_set,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  set_idx_t          wr_set,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  output logic [XLEN-1:0]   rdata
);
  logic [XLEN-1:0] stored;
  logic            hit;

  always_comb begin
    stored = '0;
    for (int k = 0; k < NUM_SETS; k++) begin
      if (sel_set == SET_W'(k)) stored = bank_data[k];
    end
  end

  assign hit   = wr_en && (wr_addr == addr) && (addr != '0) && (wr_set == sel_set);
  assign rdata = hit ? wr_data : stored;
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import rf_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int XLEN     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        rd_a_addr,
  input  logic              rd_a_prev,
  output logic [XLEN-1:0]   rd_a_data,
  input  logic [4:0]        rd_b_addr,
  output logic [XLEN-1:0]   rd_b_data,
  input  logic              wr_en,
  input  logic              wr_prev,
  input  logic [4:0]        wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              irq_enter,
  input  logic [2:0]        irq_set,
  input  logic              irq_return,
  output logic [2:0]        cur_set,
  output logic [2:0]        prev_set
);
  set_idx_t        wr_set, a_set;
  logic [XLEN-1:0] a_bank [NUM_SETS];
  logic [XLEN-1:0] b_bank [NUM_SETS];

  rf_set_ctrl #(.NUM_SETS(NUM_SETS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_enter(irq_enter), .irq_set(irq_set),
    .irq_return(irq_return), .cur_q(cur_set), .prev_q(prev_set)
  );

  assign wr_set = wr_prev   ? prev_set : cur_set;
  assign a_set  = rd_a_prev ? prev_set : cur_set;

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
    logic bank_we;
    assign bank_we = wr_en && (wr_set == SET_W'(k));
    rf_bank #(.XLEN(XLEN)) u_bank (
      .clk(clk), .we(bank_we), .waddr(wr_addr), .wdata(wr_data),
      .raddr_a(rd_a_addr), .raddr_b(rd_b_addr),
      .rdata_a(a_bank[k]), .rdata_b(b_bank[k])
    );
  end

  rf_read_port #(.NUM_SETS(NUM_SETS), .XLEN(XLEN)) u_rd_a (
    .bank_data(a_bank), .sel_set(a_set), .addr(rd_a_addr), .wr_en(wr_en),
    .wr_set(wr_set), .wr_addr(wr_addr), .wr_data(wr_data), .rdata(rd_a_data)
  );

  rf_read_port #(.NUM_SETS(NUM_SETS), .XLEN(XLEN)) u_rd_b (
    .bank_data(b_bank), .sel_set(cur_set), .addr(rd_b_addr), .wr_en(wr_en),
    .wr_set(wr_set), .wr_addr(wr_addr), .wr_data(wr_data), .rdata(rd_b_data)
  );
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int NUM_SETS = 8,
  parameter int XLEN     = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      rd_a_addr,
  input logic            rd_a_prev,
  input logic [XLEN-1:0] rd_a_data,
  input logic [4:0]      rd_b_addr,
  input logic [XLEN-1:0] rd_b_data,
  input logic            wr_en,
  input logic            wr_prev,
  input logic [4:0]      wr_addr,
  input logic [XLEN-1:0] wr_data,
  input logic            irq_enter,
  input logic [2:0]      irq_set,
  input logic            irq_return,
  input logic [2:0]      cur_set,
  input logic [2:0]      prev_set
);
  logic set_ok;
  assign set_ok = {1'b0, irq_set} < 4'(NUM_SETS);

  p_zero_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == 5'd0) |-> (rd_a_data == '0));
  p_zero_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_addr == 5'd0) |-> (rd_b_data == '0));
  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_prev && wr_addr != 5'd0 && rd_b_addr == wr_addr) |-> (rd_b_data == wr_data));
  p_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && set_ok) |=> (cur_set == $past(irq_set) && prev_set == $past(cur_set)));
  p_bad_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && !set_ok) |=> ($stable(cur_set) && $stable(prev_set)));
  p_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_enter) |=> (cur_set == $past(prev_set) && $stable(prev_set)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_enter && !irq_return) |=> ($stable(cur_set) && $stable(prev_set)));
  p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cur_set} < 4'(NUM_SETS)) && ({1'b0, prev_set} < 4'(NUM_SETS)));
endmodule

bind bank_regfile rf_checker #(.NUM_SETS(NUM_SETS), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_a_addr(rd_a_addr), .rd_a_prev(rd_a_prev),
  .rd_a_data(rd_a_data), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_prev(wr_prev), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq_enter(irq_enter), .irq_set(irq_set), .irq_return(irq_return),
  .cur_set(cur_set), .prev_set(prev_set)
);

// File: tb/sim_bank_regfile.sv
module sim_bank_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic        clk, rst_n;
  logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic        rd_a_prev, wr_en, wr_prev, irq_enter, irq_return;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic [2:0]  irq_set, cur_set, prev_set;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mdl [NS][32];
  int m_cur = 0, m_prev = 0;

  bank_regfile #(.NUM_SETS(NS), .XLEN(32)) u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(int s, int r);
    return (32'(s + 1) << 28) ^ (32'(r) * 32'h0001_0203) ^ 32'h0055_AA00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_enter(int s);
    irq_enter = 1'b1; irq_set = 3'(s);
    tick();
    irq_enter = 1'b0;
    if (s < NS) begin m_prev = m_cur; m_cur = s; end
  endtask

  task automatic do_write(int r, logic [31:0] d, logic to_prev);
    wr_en = 1'b1; wr_addr = 5'(r); wr_data = d; wr_prev = to_prev;
    tick();
    wr_en = 1'b0; wr_prev = 1'b0;
    if (r != 0) mdl[to_prev ? m_prev : m_cur][r] = d;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; wr_data = '0;
    rd_a_prev = 1'b0; wr_en = 1'b0; wr_prev = 1'b0; irq_enter = 1'b0;
    irq_return = 1'b0; irq_set = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 cur", 32'(cur_set), 0);
    chk("R1 prev", 32'(prev_set), 0);

    // Fill every set; each write is checked through the same-cycle bypass (R4)
    for (int s = 0; s < NS; s++) begin
      if (s > 0) begin
        do_enter(s);
        chk("R5 cur", 32'(cur_set), 32'(s));
        chk("R5 prev", 32'(prev_set), 32'(s - 1));
      end
      for (int r = 1; r < 32; r++) begin
        wr_en = 1'b1; wr_addr = 5'(r); wr_data = pat(s, r); rd_b_addr = 5'(r);
        #1 chk("R4 bypass", rd_b_data, pat(s, r));
        tick();
        mdl[s][r] = pat(s, r);
      end
      wr_en = 1'b0;
      // R2 write to register 0 is discarded
      do_write(0, 32'hDEAD_BEEF, 1'b0);
      rd_a_addr = 5'd0; rd_b_addr = 5'd0; rd_a_prev = 1'b0;
      #1 chk("R2 port A zero", rd_a_data, 0);
      chk("R2 port B zero", rd_b_data, 0);
    end

    // R3 / R8: current set on B, previous set on A
    for (int r = 0; r < 32; r++) begin
      rd_b_addr = 5'(r); rd_a_addr = 5'(r); rd_a_prev = 1'b1;
      #1 chk("R3 current set", rd_b_data, r == 0 ? 32'd0 : mdl[m_cur][r]);
      chk("R8 prev read", rd_a_data, r == 0 ? 32'd0 : mdl[m_prev][r]);
    end

    // R8 write to previous set, with prev-side bypass (R4)
    wr_en = 1'b1; wr_prev = 1'b1; wr_addr = 5'd5; wr_data = 32'h0BAD_F00D;
    rd_a_addr = 5'd5; rd_a_prev = 1'b1; rd_b_addr = 5'd5;
    #1 chk("R4 prev bypass", rd_a_data, 32'h0BAD_F00D);
    chk("R8 current untouched", rd_b_data, mdl[m_cur][5]);
    tick();
    wr_en = 1'b0; wr_prev = 1'b0;
    mdl[m_prev][5] = 32'h0BAD_F00D;
    #1 chk("R8 prev written", rd_a_data, 32'h0BAD_F00D);
    chk("R8 current kept", rd_b_data, mdl[m_cur][5]);

    // R6 out-of-range target ignored
    for (int bad = NS; bad < 8; bad++) begin
      do_enter(bad);
      chk("R6 cur", 32'(cur_set), 32'(m_cur));
      chk("R6 prev", 32'(prev_set), 32'(m_prev));
    end

    // R9 idle cycles hold
    tick(); tick();
    chk("R9 cur", 32'(cur_set), 32'(m_cur));
    chk("R9 prev", 32'(prev_set), 32'(m_prev));

    // R5 write in the switch cycle lands in the old set
    wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h7777_1234;
    mdl[m_cur][7] = 32'h7777_1234;
    do_enter(0);
    wr_en = 1'b0;
    chk("R5 cur after", 32'(cur_set), 0);
    chk("R5 prev after", 32'(prev_set), 32'(m_prev));
    rd_a_addr = 5'd7; rd_a_prev = 1'b1; rd_b_addr = 5'd7;
    #1 chk("R5 write old set", rd_a_data, 32'h7777_1234);
    chk("R5 new set untouched", rd_b_data, mdl[0][7]);

    // R7 return
    irq_return = 1'b1; tick(); irq_return = 1'b0;
    m_cur = m_prev;
    chk("R7 cur", 32'(cur_set), 32'(m_cur));
    chk("R7 prev", 32'(prev_set), 32'(m_prev));
    #1 chk("R7 data restored", rd_b_data, 32'h7777_1234);

    // R7 entry wins over return
    irq_return = 1'b1;
    do_enter(1);
    irq_return = 1'b0;
    chk("R7 enter wins cur", 32'(cur_set), 1);
    chk("R7 enter wins prev", 32'(prev_set), 32'(m_prev));

    // R3 final sweep of every set, isolation between sets
    for (int s = 0; s < NS; s++) begin
      do_enter(s);
      for (int r = 0; r < 32; r++) begin
        rd_b_addr = 5'(r); rd_a_addr = 5'(r); rd_a_prev = 1'b1;
        #1 chk("R3 sweep cur", rd_b_data, r == 0 ? 32'd0 : mdl[s][r]);
        chk("R8 sweep prev", rd_a_data, r == 0 ? 32'd0 : mdl[m_prev][r]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule